// File: doc/BRIEF.md
# Lockable Boot Memory Window

This block presents one contiguous byte window to a host processor. The low part of the window is a boot ROM of `ROM_BYTES` bytes. A scratch RAM of `RAM_BYTES` bytes follows directly after it, so with the default sizes the RAM starts at window address 0x7C0 and ends at 0x7FF. The ROM contents are not stored. Each byte is computed from its address and the `ROM_SEED` parameter, which gives every instance a fixed, known image without a large table. The host reaches the window over a request/acknowledge bus. The host pulses `host_req` with the address, the write enable and the data. The block answers with a one-cycle `host_ack` and, for a read, the data on `host_rdata` in that same cycle.

The top RAM byte is the command byte. Any host write to it rings a doorbell flag. The flag tells an internal command engine that work is waiting, and the engine clears it with `eng_done` when it has finished. The same write can also lock the ROM. After the lock, ROM reads return zero, so the boot image stays hidden once boot code has handed over. The lock can only be cleared by a pulse from the reset sequencer or by power-on reset. Internal logic can write the RAM through a side port, for example to leave a seed value for boot code.

The host handshake is a two-state machine: `H_IDLE` → `H_ACK` when a request is seen, and `H_ACK` → `H_IDLE` always. The lock is a two-state machine: `LK_OPEN` → `LK_SHUT` on a lock-setting command write with no unlock in the same cycle, and `LK_SHUT` → `LK_OPEN` on an unlock pulse. The doorbell is a two-state machine: `DB_IDLE` → `DB_RING` on any host command write, and `DB_RING` → `DB_IDLE` on `eng_done` with no command write in the same cycle.

Top module: `boot_window`

## Requirements
- R1: After reset, `host_ack` and `doorbell` are low, the ROM is unlocked and every RAM byte reads as 0x00.
- R2: A request seen in the idle state is acknowledged for exactly one cycle, in the cycle after it is sampled. A request held high through the acknowledge cycle is ignored in that cycle.
- R3: With the ROM unlocked, a read of address a < `ROM_BYTES` returns ((a*7 + `ROM_SEED`) mod 256) XOR ((a >> 8) mod 256). Host writes to ROM addresses have no effect.
- R4: A host write to RAM address `ROM_BYTES`+i (i < `RAM_BYTES`) stores the byte, and a later read returns it. This holds whether or not the ROM is locked.
- R5: A host write to the command byte with bit 5 of the data set locks the ROM. While the ROM is locked, ROM reads return 0x00 and are still acknowledged.
- R6: The lock stays set through later command writes with bit 5 clear. It is cleared only by `rom_unlock` or by reset. When `rom_unlock` coincides with a lock-setting write, the ROM stays unlocked.
- R7: Any host write to the command byte sets `doorbell` from the next cycle. A host read of the command byte returns the doorbell state in bit 7 and the stored bits 6..0 below it.
- R8: `eng_done` clears `doorbell` from the next cycle, except when a host command-byte write falls in the same cycle, in which case `doorbell` stays set.
- R9: A side-port write stores `side_wdata` at RAM index `side_addr`, and the host can read it back. A side-port write to the command byte does not ring the doorbell.
- R10: When the host and the side port write the same RAM byte in the same cycle, the host data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host request strobe |
| host_we | input | 1 | Host write enable (1 = write) |
| host_addr | input | ADDR_W (11) | Host window address |
| host_wdata | input | 8 | Host write data |
| host_ack | output | 1 | One-cycle acknowledge |
| host_rdata | output | 8 | Read data, valid while `host_ack` is high |
| side_we | input | 1 | Internal RAM write enable |
| side_addr | input | RAM_AW (6) | Internal RAM byte index |
| side_wdata | input | 8 | Internal RAM write data |
| eng_done | input | 1 | Command engine finished, clears the doorbell |
| rom_unlock | input | 1 | Reset-sequencer pulse that clears the lock |
| doorbell | output | 1 | Command pending for the engine |

## Verification
The hardest cases are the same-cycle collisions: unlock against a lock-setting write, `eng_done` against a command write, and a side write against a host write to the same byte. Each one only matters on the single edge at which the host write is committed. The bench drives the colliding input during the acknowledge cycle of its host transfer and then checks through later host reads and the `doorbell` pin. Full address sweeps over the ROM, both unlocked and locked, and over all RAM bytes cover the arithmetic image and the decode boundary at 0x7C0.

// File: rtl/boot_win_pkg.sv
package boot_win_pkg;

    typedef enum logic { H_IDLE, H_ACK }   host_st_t;
    typedef enum logic { LK_OPEN, LK_SHUT } lock_st_t;
    typedef enum logic { DB_IDLE, DB_RING } bell_st_t;

    // Boot image byte derived from the address and the seed.
    function automatic logic [7:0] rom_image(input logic [15:0] a, input logic [7:0] seed);
        logic [15:0] p;
        p = a * 16'd7 + {8'd0, seed};
        return p[7:0] ^ a[15:8];
    endfunction

endpackage

// File: rtl/boot_win_rom.sv
module boot_win_rom #(
    parameter int ADDR_W   = 11,
    parameter logic [7:0] ROM_SEED = 8'h5A
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);
    import boot_win_pkg::*;

    localparam int PAD = 16 - ADDR_W;

    always_comb begin
        data = rom_image({{PAD{1'b0}}, addr}, ROM_SEED);
    end

endmodule

// File: rtl/boot_win_ram.sv
module boot_win_ram #(
    parameter int RAM_BYTES = 64,
    parameter int RAM_AW    = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [RAM_AW-1:0] host_idx,
    input  logic [7:0]        host_wdata,
    input  logic              side_wr,
    input  logic [RAM_AW-1:0] side_idx,
    input  logic [7:0]        side_wdata,
    input  logic [RAM_AW-1:0] rd_idx,
    output logic [7:0]        rd_data
);
    logic [7:0] mem [RAM_BYTES];

    for (genvar g = 0; g < RAM_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= 8'h00;
            end else if (host_wr && host_idx == RAM_AW'(g)) begin
                mem[g] <= host_wdata;
            end else if (side_wr && side_idx == RAM_AW'(g)) begin
                mem[g] <= side_wdata;
            end
        end

        // Host data must win a same-byte collision.
        assert_host_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && side_wr && host_idx == RAM_AW'(g) && side_idx == RAM_AW'(g))
            |=> mem[g] == $past(host_wdata));
    end

    always_comb begin
        rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/boot_win_flags.sv
module boot_win_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic lock_req,
    input  logic unlock,
    input  logic done,
    output logic locked,
    output logic bell
);
    import boot_win_pkg::*;

    lock_st_t lk_q, lk_d;
    bell_st_t db_q, db_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= LK_OPEN;
            db_q <= DB_IDLE;
        end else begin
            lk_q <= lk_d;
            db_q <= db_d;
        end
    end

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN: if (lock_req && !unlock) lk_d = LK_SHUT;
            LK_SHUT: if (unlock)              lk_d = LK_OPEN;
        endcase
        db_d = db_q;
        unique case (db_q)
            DB_IDLE: if (cmd_wr)           db_d = DB_RING;
            DB_RING: if (done && !cmd_wr)  db_d = DB_IDLE;
        endcase
    end

    always_comb begin
        locked = (lk_q == LK_SHUT);
        bell   = (db_q == DB_RING);
    end

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !unlock) |=> locked);
    assert_unlock_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> !locked);
    assert_lock_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_req && !unlock) |=> locked);
    assert_bell_rings_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> bell);
    assert_bell_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bell && done && !cmd_wr) |=> !bell);

endmodule

// File: rtl/boot_win_host.sv
module boot_win_host #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              ack,
    output logic              wr_go,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        wdata_q
);
    import boot_win_pkg::*;

    host_st_t st_q, st_d;
    logic     we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= H_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= 8'h00;
        end else begin
            st_q <= st_d;
            if (st_q == H_IDLE && req) begin
                we_q    <= we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            H_IDLE: if (req) st_d = H_ACK;
            H_ACK:           st_d = H_IDLE;
        endcase
    end

    always_comb begin
        ack   = (st_q == H_ACK);
        wr_go = (st_q == H_ACK) && we_q;
    end

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && req) |=> ack);

endmodule

// File: rtl/boot_window.sv
module boot_window #(
    parameter int         ROM_BYTES = 1984,
    parameter int         RAM_BYTES = 64,
    parameter logic [7:0] ROM_SEED  = 8'h5A,
    parameter int         LOCK_BIT  = 5,
    parameter int         ADDR_W    = $clog2(ROM_BYTES + RAM_BYTES),
    parameter int         RAM_AW    = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_ack,
    output logic [7:0]        host_rdata,
    input  logic              side_we,
    input  logic [RAM_AW-1:0] side_addr,
    input  logic [7:0]        side_wdata,
    input  logic              eng_done,
    input  logic              rom_unlock,
    output logic              doorbell
);
    localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(ROM_BYTES);
    localparam logic [RAM_AW-1:0] CMD_IDX  = RAM_AW'(RAM_BYTES - 1);

    logic              wr_go;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic              in_ram;
    logic [ADDR_W-1:0] ram_off;
    logic [RAM_AW-1:0] ram_idx;
    logic              cmd_wr;
    logic              locked;
    logic [7:0]        rom_byte;
    logic [7:0]        ram_byte;

    boot_win_host #(.ADDR_W(ADDR_W)) host_i (
        .clk(clk), .rst_n(rst_n), .req(host_req), .we(host_we),
        .addr(host_addr), .wdata(host_wdata), .ack(host_ack),
        .wr_go(wr_go), .addr_q(addr_q), .wdata_q(wdata_q)
    );

    always_comb begin
        in_ram  = (addr_q >= RAM_BASE);
        ram_off = addr_q - RAM_BASE;
        ram_idx = ram_off[RAM_AW-1:0];
        cmd_wr  = wr_go && in_ram && (ram_idx == CMD_IDX);
    end

    boot_win_rom #(.ADDR_W(ADDR_W), .ROM_SEED(ROM_SEED)) rom_i (
        .addr(addr_q), .data(rom_byte)
    );

    boot_win_ram #(.RAM_BYTES(RAM_BYTES), .RAM_AW(RAM_AW)) ram_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(wr_go && in_ram), .host_idx(ram_idx), .host_wdata(wdata_q),
        .side_wr(side_we), .side_idx(side_addr), .side_wdata(side_wdata),
        .rd_idx(ram_idx), .rd_data(ram_byte)
    );

    boot_win_flags flags_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .lock_req(cmd_wr && wdata_q[LOCK_BIT]), .unlock(rom_unlock),
        .done(eng_done), .locked(locked), .bell(doorbell)
    );

    always_comb begin
        if (!host_ack)                host_rdata = 8'h00;
        else if (in_ram && ram_idx == CMD_IDX)
                                      host_rdata = {doorbell, ram_byte[6:0]};
        else if (in_ram)              host_rdata = ram_byte;
        else if (locked)              host_rdata = 8'h00;
        else                          host_rdata = rom_byte;
    end

    assert_locked_rom_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !in_ram && locked) |-> host_rdata == 8'h00);
    assert_bell_only_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!doorbell && !cmd_wr) |=> !doorbell);

endmodule

// File: tb/boot_window_tb_top.sv
module boot_window_tb_top;
    localparam int ROM_BYTES = 1984;
    localparam int RAM_BYTES = 64;
    localparam logic [7:0] SEED = 8'h5A;
    localparam logic [10:0] CMD_A = 11'h7FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic        side_we = 1'b0;
    logic [5:0]  side_addr = '0;
    logic [7:0]  side_wdata = '0;
    logic        eng_done = 1'b0, rom_unlock = 1'b0;
    logic        doorbell;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    boot_window dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .side_we(side_we), .side_addr(side_addr),
        .side_wdata(side_wdata), .eng_done(eng_done), .rom_unlock(rom_unlock),
        .doorbell(doorbell)
    );

    function automatic logic [7:0] exp_rom(input int a);
        return 8'(((a * 7 + int'(SEED)) % 256) ^ ((a >> 8) % 256));
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // extra: 0 none, 1 side write, 2 done, 3 unlock, asserted during the ack cycle
    task automatic xfer(input logic we, input logic [10:0] a, input logic [7:0] d,
                        input int extra, output logic [7:0] q);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        q = host_rdata;
        if (!host_ack) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 ack missing actual=0 expected=1");
        end
        if (extra != 0) begin
            side_we = (extra == 1); eng_done = (extra == 2); rom_unlock = (extra == 3);
            @(negedge clk);
            side_we = 1'b0; eng_done = 1'b0; rom_unlock = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack", {7'd0, host_ack}, 8'h00);
        chk("R1 doorbell", {7'd0, doorbell}, 8'h00);
        for (int i = 0; i < RAM_BYTES; i++) begin
            xfer(1'b0, 11'(ROM_BYTES + i), 8'h00, 0, q);
            chk("R1 ram zero", q, 8'h00);
        end
        // R2 single-cycle ack, request held through ack ignored
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 11'd3;
        @(negedge clk);
        chk("R2 ack high", {7'd0, host_ack}, 8'h01);
        @(negedge clk);
        host_req = 1'b0;
        chk("R2 ack one cycle", {7'd0, host_ack}, 8'h00);
        @(negedge clk);
        chk("R2 held req ignored", {7'd0, host_ack}, 8'h00);
        // R3 full ROM sweep, unlocked
        errs = n_bad;
        for (int a = 0; a < ROM_BYTES; a++) begin
            xfer(1'b0, 11'(a), 8'h00, 0, q);
            chk("R3 rom image", q, exp_rom(a));
        end
        // R3 writes to ROM have no effect
        xfer(1'b1, 11'd10, 8'hFF, 0, q);
        xfer(1'b0, 11'd10, 8'h00, 0, q);
        chk("R3 rom write ignored", q, exp_rom(10));
        // R4 RAM sweep (command byte avoided)
        for (int i = 0; i < RAM_BYTES - 1; i++)
            xfer(1'b1, 11'(ROM_BYTES + i), 8'((i * 13 + 1) % 256), 0, q);
        for (int i = 0; i < RAM_BYTES - 1; i++) begin
            xfer(1'b0, 11'(ROM_BYTES + i), 8'h00, 0, q);
            chk("R4 ram readback", q, 8'((i * 13 + 1) % 256));
        end
        // R7 doorbell and command readback
        xfer(1'b1, CMD_A, 8'h13, 0, q);
        @(negedge clk);
        chk("R7 doorbell set", {7'd0, doorbell}, 8'h01);
        xfer(1'b0, CMD_A, 8'h00, 0, q);
        chk("R7 cmd read bit7", q, 8'h93);
        // R8 done clears
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        chk("R8 doorbell cleared", {7'd0, doorbell}, 8'h00);
        xfer(1'b0, CMD_A, 8'h00, 0, q);
        chk("R8 cmd read after done", q, 8'h13);
        // R8 done colliding with command write keeps doorbell
        xfer(1'b1, CMD_A, 8'h01, 2, q);
        chk("R8 collision keeps doorbell", {7'd0, doorbell}, 8'h01);
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        // R5 lock
        xfer(1'b1, CMD_A, 8'h20, 0, q);
        errs = n_bad;
        for (int a = 0; a < ROM_BYTES; a++) begin
            xfer(1'b0, 11'(a), 8'h00, 0, q);
            chk("R5 locked rom blank", q, 8'h00);
        end
        // R4 RAM still accessible under lock
        xfer(1'b1, 11'h7C4, 8'hC3, 0, q);
        xfer(1'b0, 11'h7C4, 8'h00, 0, q);
        chk("R4 ram under lock", q, 8'hC3);
        // R6 sticky
        xfer(1'b1, CMD_A, 8'h00, 0, q);
        xfer(1'b0, 11'd100, 8'h00, 0, q);
        chk("R6 lock sticky", q, 8'h00);
        @(negedge clk); rom_unlock = 1'b1;
        @(negedge clk); rom_unlock = 1'b0;
        xfer(1'b0, 11'd100, 8'h00, 0, q);
        chk("R6 unlock reopens", q, exp_rom(100));
        // R6 unlock colliding with lock write: stays open
        xfer(1'b1, CMD_A, 8'h20, 3, q);
        xfer(1'b0, 11'd1983, 8'h00, 0, q);
        chk("R6 unlock wins", q, exp_rom(1983));
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        // R9 side port writes
        @(negedge clk); side_we = 1'b1; side_addr = 6'd36; side_wdata = 8'hA7;
        @(negedge clk); side_we = 1'b0;
        xfer(1'b0, 11'h7E4, 8'h00, 0, q);
        chk("R9 side write", q, 8'hA7);
        @(negedge clk); side_we = 1'b1; side_addr = 6'd63; side_wdata = 8'h05;
        @(negedge clk); side_we = 1'b0;
        chk("R9 side no doorbell", {7'd0, doorbell}, 8'h00);
        xfer(1'b0, CMD_A, 8'h00, 0, q);
        chk("R9 side cmd data", q, 8'h05);
        // R10 collision, host wins
        side_addr = 6'd7; side_wdata = 8'h11;
        xfer(1'b1, 11'h7C7, 8'h99, 1, q);
        xfer(1'b0, 11'h7C7, 8'h00, 0, q);
        chk("R10 host wins", q, 8'h99);
        // R10 side write to a different byte in same cycle still lands
        side_addr = 6'd8; side_wdata = 8'h22;
        xfer(1'b1, 11'h7C7, 8'h44, 1, q);
        xfer(1'b0, 11'h7C8, 8'h00, 0, q);
        chk("R10 side other byte", q, 8'h22);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule